// File: doc/BRIEF.md
# Aligned Power-of-Two Window Decomposer

This engine takes one address region, described by a base address, a byte length, a translation offset and a kind (memory or I/O), and breaks it into a run of naturally aligned, power-of-two sized windows. A downstream address translator can hold each window as a (match, remap, mask) tuple. Setup logic pulses `start_i` with the region and the number of translator slots already taken. The engine then walks the region and emits one window record per clock. It stops when the region is used up, when the slot budget is exhausted, or when the next window would break a rule.

Each step takes the largest power of two that is no bigger than the bytes still left and that keeps the current base naturally aligned. A window smaller than 64 KiB is rejected. A window whose translated (remapped) base is not aligned to its own size is rejected too. When a run ends, `done_o` pulses once. `err_o` reports whether part of the region was left uncovered, and `slots_o` gives the slot count after the run. Both hold until the next accepted start.

Top module: `win_decomp`

## Requirements
- R1: `start_i` is accepted only while `busy_o` is low. A start pulse seen while busy has no effect on the windows being emitted or on the final result.
- R2: The first window record appears with `win_valid_o` high in the second cycle after the start is accepted. After that, exactly one record is emitted per clock until the run ends.
- R3: Each window size is 2^k. Here k is the bit index of the highest set bit of the remaining size, lowered to the bit index of the lowest set bit of the current base when the base is nonzero and that index is smaller. `win_mask_o` is NOT(size − 1). Consecutive windows are contiguous.
- R4: `win_match_o` equals the current base. `win_remap_o` equals the current base minus the offset, modulo 2^64. `win_type_o` is 4'h4 for an I/O region and 4'h0 for a memory region.
- R5: If the chosen size is below 0x10000, the run stops without emitting that window.
- R6: If the remapped base has any bit set below the chosen size, the run stops without emitting that window.
- R7: The number of used slots never goes beyond 8. The run starts counting from `slots_used_i`. A run that starts with 8 or more slots used emits no window.
- R8: `done_o` pulses for one cycle, in the cycle after the last window (or after the start cycle's successor if no window is emitted). It never coincides with `win_valid_o`. With it, `err_o` is 1 exactly when some size is left uncovered, and `slots_o` is the final slot count.
- R9: A memory region with zero offset emits no window. It completes with `err_o` low and `slots_o` equal to `slots_used_i`.
- R10: After reset, `win_valid_o`, `done_o`, `busy_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe for a new region |
| base_i | input | 64 | Region start address |
| size_i | input | 64 | Region length in bytes |
| offset_i | input | 64 | Translation offset (remap = base − offset) |
| is_io_i | input | 1 | 1 selects an I/O region, 0 a memory region |
| slots_used_i | input | 4 | Slots already taken before this region |
| busy_o | output | 1 | Run in progress |
| win_valid_o | output | 1 | Window record valid this cycle |
| win_match_o | output | 64 | Window match address |
| win_remap_o | output | 64 | Window remapped address |
| win_mask_o | output | 64 | Window address mask |
| win_type_o | output | 4 | Window action type |
| done_o | output | 1 | One-cycle end-of-run pulse |
| err_o | output | 1 | Region not fully covered (held) |
| slots_o | output | 4 | Slot count after the run (held) |

## Verification
The bench checks each of these corner cases against a behavioural model:
- A base whose alignment, not the remaining length, limits the first windows, so sizes grow as the base climbs. A design that scanned the wrong end of the base would emit oversized, misaligned windows.
- A tail shorter than 64 KiB, and an offset that breaks the alignment of the remap. A design that skipped either rule would emit an illegal window and report no error.
- Slot budgets that run out partway through a run and ones that are full from the start. A design with an off-by-one here would emit a ninth window.
- A start pulse in the middle of a run, and a memory region with zero offset. A design that got these wrong would either restart the walk or emit windows that are not needed.

// File: rtl/win_decomp_pkg.sv
package win_decomp_pkg;
  typedef enum logic [3:0] {
    WT_MEM = 4'h0,
    WT_IO  = 4'h4
  } win_type_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;
endpackage

// File: rtl/bit_scan.sv
// Priority encoder: index of highest (FROM_TOP=1) or lowest set bit.
module bit_scan #(
  parameter int W = 64,
  parameter bit FROM_TOP = 1'b1,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  assign any_o = |vec_i;

  if (FROM_TOP) begin : g_hi
    always_comb begin
      idx_o = '0;
      for (int i = 0; i < W; i++)
        if (vec_i[i]) idx_o = IW'(i);
    end
  end else begin : g_lo
    always_comb begin
      idx_o = '0;
      for (int i = W - 1; i >= 0; i--)
        if (vec_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/win_step.sv
// One decomposition step: pick window size and check its legality.
module win_step #(
  parameter int AW = 64,
  parameter int MIN_LOG2 = 16,
  localparam int LW = $clog2(AW)
) (
  input  logic [AW-1:0] cur_i,
  input  logic [AW-1:0] rem_i,
  input  logic [AW-1:0] off_i,
  output logic [AW-1:0] size_o,
  output logic [AW-1:0] mask_o,
  output logic [AW-1:0] remap_o,
  output logic          ok_o
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [LW-1:0] hi_idx, lo_idx, lg;
  logic          hi_any, lo_any;

  bit_scan #(.W(AW), .FROM_TOP(1'b1)) u_scan_rem (
    .vec_i(rem_i), .idx_o(hi_idx), .any_o(hi_any)
  );
  bit_scan #(.W(AW), .FROM_TOP(1'b0)) u_scan_cur (
    .vec_i(cur_i), .idx_o(lo_idx), .any_o(lo_any)
  );

  // alignment of the base caps the size only when the base is nonzero
  assign lg      = (lo_any && (lo_idx < hi_idx)) ? lo_idx : hi_idx;
  assign size_o  = ONE << lg;
  assign mask_o  = ~(size_o - ONE);
  assign remap_o = cur_i - off_i;
  assign ok_o    = hi_any && (lg >= LW'(MIN_LOG2)) && ((remap_o & ~mask_o) == '0);
endmodule

// File: rtl/win_decomp.sv
module win_decomp
  import win_decomp_pkg::*;
#(
  parameter int AW = 64,
  parameter int MAX_WIN = 8,
  parameter int MIN_LOG2 = 16,
  localparam int SW = $clog2(MAX_WIN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] size_i,
  input  logic [AW-1:0] offset_i,
  input  logic          is_io_i,
  input  logic [SW-1:0] slots_used_i,
  output logic          busy_o,
  output logic          win_valid_o,
  output logic [AW-1:0] win_match_o,
  output logic [AW-1:0] win_remap_o,
  output logic [AW-1:0] win_mask_o,
  output logic [3:0]    win_type_o,
  output logic          done_o,
  output logic          err_o,
  output logic [SW-1:0] slots_o
);
  localparam logic [AW-1:0] ONE = AW'(1);

  run_state_e    state_q;
  logic [AW-1:0] cur_q, rem_q, off_q;
  logic          io_q;
  logic [SW-1:0] cnt_q;

  logic [AW-1:0] st_size, st_mask, st_remap;
  logic          st_ok, slots_full, finish;

  win_step #(.AW(AW), .MIN_LOG2(MIN_LOG2)) u_step (
    .cur_i(cur_q), .rem_i(rem_q), .off_i(off_q),
    .size_o(st_size), .mask_o(st_mask), .remap_o(st_remap), .ok_o(st_ok)
  );

  assign slots_full = cnt_q >= SW'(MAX_WIN);
  assign finish     = (rem_q == '0) || slots_full || !st_ok;
  assign busy_o     = (state_q == ST_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cur_q       <= '0;
      rem_q       <= '0;
      off_q       <= '0;
      io_q        <= 1'b0;
      cnt_q       <= '0;
      win_valid_o <= 1'b0;
      win_match_o <= '0;
      win_remap_o <= '0;
      win_mask_o  <= '0;
      win_type_o  <= WT_MEM;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
      slots_o     <= '0;
    end else begin
      win_valid_o <= 1'b0;
      done_o      <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RUN;
          cur_q   <= base_i;
          // transparent memory: nothing to map, exit on first run cycle
          rem_q   <= (!is_io_i && offset_i == '0) ? '0 : size_i;
          off_q   <= offset_i;
          io_q    <= is_io_i;
          cnt_q   <= slots_used_i;
          err_o   <= 1'b0;
        end
        ST_RUN: if (finish) begin
          state_q <= ST_IDLE;
          done_o  <= 1'b1;
          err_o   <= (rem_q != '0);
          slots_o <= cnt_q;
        end else begin
          win_valid_o <= 1'b1;
          win_match_o <= cur_q;
          win_remap_o <= st_remap;
          win_mask_o  <= st_mask;
          win_type_o  <= io_q ? WT_IO : WT_MEM;
          cur_q       <= cur_q + st_size;
          rem_q       <= rem_q - st_size;
          cnt_q       <= cnt_q + SW'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_VALID_NOT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(win_valid_o && done_o)); // R8
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R8
  AST_SLOT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid_o |-> (cnt_q <= SW'(MAX_WIN))); // R7
  AST_MASK_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid_o |-> (win_mask_o[MIN_LOG2-1:0] == '0)); // R5
  AST_REMAP_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid_o |-> ((win_remap_o & ~win_mask_o) == '0)); // R6
  AST_MATCH_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid_o |-> ((win_match_o & ~win_mask_o) == '0)); // R3
  AST_CONTIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_valid_o && $past(win_valid_o)) |->
      (win_match_o == $past(win_match_o) + ~$past(win_mask_o) + ONE)); // R3
  AST_RUN_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !finish) |=> busy_o); // R1
endmodule

// File: tb/win_decomp_tb_top.sv
module win_decomp_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [63:0] base_i = '0, size_i = '0, offset_i = '0;
  logic        is_io_i = 1'b0;
  logic [3:0]  slots_used_i = '0;
  logic        busy_o, win_valid_o, done_o, err_o;
  logic [63:0] win_match_o, win_remap_o, win_mask_o;
  logic [3:0]  win_type_o, slots_o;

  always #5 clk_i = ~clk_i;

  win_decomp dut_i (.*);

  typedef struct {
    bit          v;
    bit          d;
    logic [63:0] match, remap, mask;
    logic [3:0]  typ;
    bit          err;
    logic [3:0]  slots;
    string       tag;
  } ev_t;

  ev_t exp_q[$];
  int  total = 0, bad = 0;
  bit  cmp_en = 1'b0, finished = 1'b0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // behavioural model: full event list for one accepted start
  task automatic model(logic [63:0] base, logic [63:0] size, logic [63:0] off,
                       bit io, int used, string tag);
    ev_t e;
    logic [63:0] cur = base, rem = size, sz, rm;
    int cnt = used, hi, lo, lg;
    e = '{v:0, d:0, match:0, remap:0, mask:0, typ:0, err:0, slots:0, tag:tag};
    exp_q.push_back(e);
    exp_q.push_back(e);
    if (!io && off == 0) rem = 0;
    while (1) begin
      if (rem == 0 || cnt >= 8) break;
      hi = 0;
      for (int b = 0; b < 64; b++) if (rem[b]) hi = b;
      lg = hi;
      if (cur != 0) begin
        lo = 63;
        for (int b = 63; b >= 0; b--) if (cur[b]) lo = b;
        if (lo < lg) lg = lo;
      end
      sz = 64'd1 << lg;
      if (sz < 64'h10000) break;
      rm = cur - off;
      if ((rm & (sz - 1)) != 0) break;
      e.v = 1; e.match = cur; e.remap = rm; e.mask = ~(sz - 1);
      e.typ = io ? 4'h4 : 4'h0;
      exp_q.push_back(e);
      cur += sz; rem -= sz; cnt++;
    end
    e.v = 0; e.d = 1; e.err = (rem != 0); e.slots = 4'(cnt);
    exp_q.push_back(e);
  endtask

  always @(negedge clk_i) if (cmp_en) begin
    ev_t e;
    if (exp_q.size() != 0) begin
      e = exp_q.pop_front();
      chk({e.tag, " R2 valid"}, 64'(win_valid_o), 64'(e.v));
      chk({e.tag, " R8 done"}, 64'(done_o), 64'(e.d));
      if (e.v && win_valid_o) begin
        chk({e.tag, " R4 match"}, win_match_o, e.match);
        chk({e.tag, " R4 remap"}, win_remap_o, e.remap);
        chk({e.tag, " R3 mask"}, win_mask_o, e.mask);
        chk({e.tag, " R4 type"}, 64'(win_type_o), 64'(e.typ));
      end
      if (e.d) begin
        chk({e.tag, " R8 err"}, 64'(err_o), 64'(e.err));
        chk({e.tag, " R8 slots"}, 64'(slots_o), 64'(e.slots));
      end
    end else begin
      chk("idle R2 valid", 64'(win_valid_o), 64'd0);
      chk("idle R8 done", 64'(done_o), 64'd0);
    end
  end

  task automatic run_case(logic [63:0] base, logic [63:0] size, logic [63:0] off,
                          bit io, int used, string tag, bit poke);
    @(posedge clk_i); #2;
    base_i = base; size_i = size; offset_i = off; is_io_i = io;
    slots_used_i = 4'(used); start_i = 1'b1;
    model(base, size, off, io, used, tag);
    @(posedge clk_i); #2;
    start_i = 1'b0;
    if (poke) begin
      @(posedge clk_i); #2;
      chk("R1 busy during run", 64'(busy_o), 64'd1);
      base_i = 64'h1234_0000; size_i = 64'h10000; offset_i = 64'h0;
      is_io_i = 1'b1; slots_used_i = 4'd7; start_i = 1'b1;
      @(posedge clk_i); #2;
      start_i = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #2;
    chk("R10 valid", 64'(win_valid_o), 64'd0);
    chk("R10 done", 64'(done_o), 64'd0);
    chk("R10 busy", 64'(busy_o), 64'd0);
    chk("R10 err", 64'(err_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    cmp_en = 1'b1;
    run_case(64'h0, 64'h100000, 64'h0, 1'b0, 2, "R9 mem zero offset", 1'b0);
    run_case(64'h0, 64'h30000, 64'h0, 1'b1, 0, "R4 io from zero", 1'b0);
    run_case(64'h10000, 64'h70000, 64'h1000_0000, 1'b0, 1, "R3 base limited", 1'b0);
    run_case(64'hF_0000_0000, 64'h40000, 64'h10_0000_0000, 1'b1, 0, "R4 wrap remap", 1'b0);
    run_case(64'h0, 64'h18000, 64'h0, 1'b1, 0, "R5 short tail", 1'b0);
    run_case(64'h100000, 64'h100000, 64'h88000, 1'b0, 0, "R6 remap misaligned", 1'b0);
    run_case(64'h80000, 64'h200000, 64'h80000, 1'b0, 3, "R6 partial align", 1'b0);
    run_case(64'h10000, 64'h1000_0000, 64'h0, 1'b1, 6, "R7 budget runs out", 1'b0);
    run_case(64'h0, 64'h100000, 64'h0, 1'b1, 8, "R7 budget full", 1'b0);
    run_case(64'h10000, 64'hFF0000, 64'h0, 1'b1, 0, "R1 start while busy", 1'b1);
    run_case(64'h40000, 64'h40000, 64'h0, 1'b1, 5, "R2 single window", 1'b0);
    repeat (3) @(negedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule